// File: doc/BRIEF.md
# Latched Parallel Output Port

This block is a write-only port that a microcontroller drives through its general-purpose pins. It sets a bank of output-enable bits, one per channel. The processor holds chip select low and pulses write low to load a byte into an input latch. The byte reaches the outputs only when chip select is released.

Holding both strobes low for long enough turns the port into a transparent path, so the data pins steer the outputs directly. An active-low disable input clears the outputs and the input latch without waiting for a clock. After disable is released, the outputs stay off until a new byte has been written and committed.

All strobe and data inputs are sampled by a local clock through a multi-flop synchronizer. Every edge decision is taken on the synchronized copies.

Top module: `par_out_port`

## Requirements
- R1: After reset, every output bit is 0.
- R2: While synchronized chip select and write are both low, each clock loads the data inputs into the input latch.
- R3: Once write is high, later changes on the data inputs do not alter the latch. The committed output equals the data present before write rose.
- R4: A rising edge of synchronized chip select copies the latch to the outputs. Before that edge the outputs keep their previous value. The outputs change on the third clock edge after the new chip-select level is first sampled.
- R5: Both strobes must stay low for at least HOLD_CYC consecutive synchronized samples before direct mode starts. A shorter write does not pass data to the outputs before chip select rises.
- R6: In direct mode, the outputs follow the synchronized data inputs on every clock for as long as both strobes stay low.
- R7: Driving dis_ni low clears all outputs at once, with no clock edge needed. It also clears the input latch. Strobe activity while dis_ni is low leaves the outputs at 0.
- R8: After dis_ni returns high, a chip-select release with no preceding write commits 0. The outputs become nonzero only after a new write followed by a commit.
- R9: Data bit n controls output bit n only, for every n below DATA_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Active-low write strobe |
| dis_ni | input | 1 | Active-low asynchronous output disable and latch clear |
| data_i | input | DATA_W | Parallel data, bit n for channel n |
| out_o | output | DATA_W | Registered output-enable bits |

## Verification
Some properties are checked on every clock in the RTL:
- the latch stays frozen whenever it is not being loaded;
- the outputs change only on a commit or in direct mode;
- a commit copies exactly the prior latch contents;
- direct mode tracks the sampled data;
- disable holds the outputs at zero;
- the direct-mode counter never passes its limit.

Other behaviours need whole transaction sequences, which only the bench scenarios can show:
- the timing of the asynchronous clear between clock edges;
- the refusal to enter direct mode on a short write;
- the rule that data changed after the write edge is ignored;
- the requirement for a fresh write after disable.

// File: rtl/par_out_pkg.sv
package par_out_pkg;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned SYNC_N_DEF   = 2;
  localparam int unsigned HOLD_CYC_DEF = 8;
endpackage

// File: rtl/par_out_sync.sv
module par_out_sync #(
  parameter int unsigned     W       = 10,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/par_out_ctl.sv
module par_out_ctl #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic cs_s_i,
  input  logic wr_s_i,
  output logic load_o,
  output logic commit_o,
  output logic direct_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYC);

  logic             cs_d_q;
  logic [CNT_W-1:0] low_cnt_q;

  assign load_o   = !cs_s_i && !wr_s_i;
  assign commit_o = cs_s_i && !cs_d_q;
  assign direct_o = (low_cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      cs_d_q    <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      cs_d_q <= cs_s_i;
      if (!load_o)                low_cnt_q <= '0;
      else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // R5: direct-mode qualifier saturates at its limit
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!clr_ni)
    low_cnt_q <= CNT_MAX);

  // R5: direct mode only reachable while both strobes stay low
  p_direct_needs_low_r5: assert property (@(posedge clk_i) disable iff (!clr_ni)
    direct_o |-> $past(load_o));
endmodule

// File: rtl/par_out_regs.sv
module par_out_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic         load_i,
  input  logic         commit_i,
  input  logic         direct_i,
  input  logic [W-1:0] d_s_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] latch_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)     latch_q <= '0;
    else if (load_i) latch_q <= d_s_i;
  end

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)        out_q <= '0;
    else if (direct_i)  out_q <= d_s_i;
    else if (commit_i)  out_q <= latch_q;
  end

  assign out_o = out_q;

  // R3: latch frozen outside a write
  p_latch_frozen_r3: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !load_i |=> $stable(latch_q));

  // R4: commit transfers prior latch contents
  p_commit_copy_r4: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (commit_i && !direct_i) |=> out_q == $past(latch_q));

  // R4: outputs hold between commits
  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (!commit_i && !direct_i) |=> $stable(out_q));

  // R6: direct mode tracks sampled data
  p_direct_track_r6: assert property (@(posedge clk_i) disable iff (!clr_ni)
    direct_i |=> out_q == $past(d_s_i));
endmodule

// File: rtl/par_out_port.sv
module par_out_port
  import par_out_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned SYNC_N   = SYNC_N_DEF,
  parameter int unsigned HOLD_CYC = HOLD_CYC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              dis_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_o
);
  localparam int unsigned            SW      = DATA_W + 2;
  localparam logic [SW-1:0]          SYNC_RV = {2'b11, {DATA_W{1'b0}}};

  logic [SW-1:0]     raw_in, syn_q;
  logic              cs_s, wr_s;
  logic [DATA_W-1:0] d_s;
  logic              clr_n;
  logic              load, commit, direct;

  // disable acts as an asynchronous clear of the whole register path
  assign clr_n  = rst_ni & dis_ni;
  assign raw_in = {cs_ni, wr_ni, data_i};

  par_out_sync #(.W(SW), .STAGES(SYNC_N), .RST_VAL(SYNC_RV)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_q)
  );

  assign {cs_s, wr_s, d_s} = syn_q;

  par_out_ctl #(.HOLD_CYC(HOLD_CYC)) u_ctl (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .cs_s_i  (cs_s),
    .wr_s_i  (wr_s),
    .load_o  (load),
    .commit_o(commit),
    .direct_o(direct)
  );

  par_out_regs #(.W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .load_i  (load),
    .commit_i(commit),
    .direct_i(direct),
    .d_s_i   (d_s),
    .out_o   (out_o)
  );

  // R7: outputs off whenever disable is held
  p_dis_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_ni |-> out_o == '0);

  // R1: reset leaves outputs clear
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> out_o == '0);
endmodule

// File: tb/par_out_port_tb_top.sv
module par_out_port_tb_top;
  localparam int unsigned CLK_PER = 10;
  localparam int unsigned DW      = 8;
  localparam int unsigned HOLD    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, wr_n = 1'b1, dis_n = 1'b1;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  par_out_port #(.DATA_W(DW), .SYNC_N(2), .HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
    .dis_ni(dis_n), .data_i(data), .out_o(out)
  );

  function automatic logic [DW-1:0] exp_commit(input logic [DW-1:0] wr_val,
                                               input bit fresh_write);
    return fresh_write ? wr_val : '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] exp);
    n_chk++;
    if (out !== exp) begin
      n_fail++;
      $display("FAIL %s: out=%h expected=%h at %0t", req, out, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // short write of val, then data changed to post before chip-select release
  task automatic write_commit(input logic [DW-1:0] val, input int low_n,
                              input logic [DW-1:0] post);
    cs_n = 1'b0; cyc(1);
    wr_n = 1'b0; data = val; cyc(low_n);
    wr_n = 1'b1; cyc(1);
    data = post; cyc(2);
    cs_n = 1'b1; cyc(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: out=%h expected=completion", out);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] prev;
    void'($urandom(32'h5eed_1234));
    cyc(3);
    check("R1 reset", '0);
    rst_n = 1'b1; cyc(3);
    check("R1 after reset release", '0);

    // R2/R3: write A, change data afterwards, commit yields A
    write_commit(8'hA5, 2, 8'h3C);
    check("R3 post-edge data ignored", 8'hA5);

    // R4: latency and hold before cs release
    cs_n = 1'b0; cyc(1);
    wr_n = 1'b0; data = 8'h5A; cyc(2);
    wr_n = 1'b1; cyc(3);
    check("R4 hold before commit", 8'hA5);
    cs_n = 1'b1; cyc(2);
    check("R4 not yet after two edges", 8'hA5);
    cyc(1);
    check("R4 committed on third edge", 8'h5A);

    // R9: walking ones
    for (int i = 0; i < DW; i++) begin
      write_commit(DW'(1) << i, 1, '0);
      check("R9 walking one", DW'(1) << i);
    end

    // R5: short both-low does not pass through; R6: long one does
    prev = out;
    cs_n = 1'b0; wr_n = 1'b0; data = 8'hC3; cyc(HOLD - 3);
    check("R5 no direct before hold", prev);
    cyc(6);
    check("R6 direct mode entered", 8'hC3);
    data = 8'h81; cyc(3);
    check("R6 direct follows data", 8'h81);
    data = 8'h7E; cyc(3);
    check("R6 direct follows again", 8'h7E);
    wr_n = 1'b1; cs_n = 1'b1; cyc(5);
    check("R6 exit keeps last", 8'h7E);

    // R7: async clear between clock edges
    @(posedge clk); #2;
    dis_n = 1'b0; #1;
    check("R7 immediate clear", '0);
    cyc(1);
    write_commit(8'hFF, 2, '0);
    check("R7 strobes ignored while disabled", '0);
    dis_n = 1'b1; cyc(2);
    check("R8 stays off after release", '0);

    // R8: commit without fresh write gives cleared latch
    write_commit(8'h99, 2, '0); // writes and commits
    check("R8 fresh write commits", exp_commit(8'h99, 1));
    dis_n = 1'b0; cyc(1); dis_n = 1'b1; cyc(2);
    cs_n = 1'b0; cyc(3); cs_n = 1'b1; cyc(5);
    check("R8 commit without write", exp_commit(8'h99, 0));

    // random short writes with post-edge data changes
    for (int k = 0; k < 40; k++) begin
      logic [DW-1:0] v, p;
      int ln;
      v  = DW'($urandom);
      p  = DW'($urandom);
      ln = 1 + int'($urandom % 3);
      write_commit(v, ln, p);
      check("R2 random write", exp_commit(v, 1));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule